// File: doc/BRIEF.md
# Sync Word Transmit Serializer

This block emits the synchronisation field of an outgoing frame as a serial bit stream. Software programs a three-byte pattern and a match length in bits. When a start pulse arrives, the block captures both. It turns the bit length into a whole number of bytes to send: three, two, one or none. It then presents those bytes on a single data line, most significant bit first, and moves to the next bit each time the downstream modulator raises a bit-enable strobe.

The sent field is always byte-aligned. For lengths that are not a multiple of eight, software fills the unused low part of the pattern with preamble bits, and the block sends the stored bytes unchanged. The bytes that go out are always the upper ones of the pattern. When more than one byte goes out, the lowest selected byte leads and the higher bytes follow in rising order. A busy flag covers the transmission, and a one-cycle done pulse marks its end. Preamble generation and payload transmission are handled by other blocks.

Top module: `sws_tx_serializer`

## Requirements
- R1: After reset, busy, done and sdata are all 0. Whenever busy is 0, sdata is 0.
- R2: A length of 17 or more sends 24 bits: pattern bits [7:0], then [15:8], then [23:16].
- R3: A length from 8 to 16, including exactly 16, sends 16 bits: pattern bits [15:8], then [23:16].
- R4: A length from 1 to 7 sends 8 bits, taken from pattern bits [23:16] only.
- R5: A length of 0 sends no bits. busy never rises, and done is 1 in the cycle after the start cycle.
- R6: Within each byte, bit 7 of the byte is sent first and bit 0 last.
- R7: sdata holds the current bit until a cycle in which busy and bit_en are both 1. The following cycle shows the next bit. bit_en while idle has no effect.
- R8: In the cycle after the bit_en that takes the final bit, busy is 0 and done is 1 for exactly that one cycle.
- R9: A start pulse while busy is ignored. The bit stream and the bit count of the running transfer are unchanged, and no new transfer follows.
- R10: Pattern and length are captured at the accepted start. Changes to them during a transfer have no effect on it.
- R11: When a start with a nonzero length is accepted, busy is 1 in the next cycle and sdata already shows the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sync transfer (single-cycle pulse) |
| bit_en | input | 1 | Current bit has been taken; advance to the next |
| sync_pattern | input | 24 | Pattern; low byte [7:0], middle [15:8], upper [23:16] |
| sync_len | input | 5 | Sync match length in bits |
| sdata | output | 1 | Serial sync bit currently presented |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the transfer ends |

## Verification
Several properties are checked every cycle. The bit counter is never zero while busy. The final take ends busy and raises done in the next cycle. An empty start gives done without busy. A start during busy leaves the count unchanged. The shift state holds when no bit is taken, and sdata is quiet while idle. Only the bench scenarios can show that the right bytes go out, in the right order and bit order, for each length band, including the edge values 7, 8, 16 and 17. The same holds for pattern and length edits during a transfer being ignored. A scoreboard compares every taken bit against a stream built from the length rules.

// File: rtl/sws_pkg.sv
package sws_pkg;

  typedef enum logic {
    SWS_IDLE = 1'b0,
    SWS_SEND = 1'b1
  } sws_state_e;

  // Bytes to send for a given match length: 0 -> none, exactly two bytes' worth
  // stays at two, otherwise one more than the whole bytes covered, capped.
  function automatic int unsigned sws_byte_count(input int unsigned len,
                                                 input int unsigned byte_w,
                                                 input int unsigned max_bytes);
    int unsigned n;
    if (len == 0)
      n = 0;
    else if (len == 2 * byte_w)
      n = 2;
    else
      n = len / byte_w + 1;
    if (n > max_bytes)
      n = max_bytes;
    return n;
  endfunction

  // Number of leading stream bits dropped when fewer than all bytes are sent.
  function automatic int unsigned sws_skip_bits(input int unsigned n_bytes,
                                                input int unsigned byte_w,
                                                input int unsigned max_bytes);
    return byte_w * (max_bytes - n_bytes);
  endfunction

endpackage

// File: rtl/sws_len_decode.sv
module sws_len_decode
  import sws_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  parameter int LEN_W     = 5,
  localparam int CNT_W    = $clog2(NUM_BYTES + 1),
  localparam int BITS_W   = $clog2(NUM_BYTES * BYTE_W + 1)
) (
  input  logic [LEN_W-1:0]  len,
  output logic [CNT_W-1:0]  n_bytes,
  output logic [BITS_W-1:0] n_bits
);

  int unsigned nb;

  always_comb begin
    nb      = sws_byte_count(32'(len), BYTE_W, NUM_BYTES);
    n_bytes = CNT_W'(nb);
    n_bits  = BITS_W'(nb * BYTE_W);
  end

endmodule

// File: rtl/sws_shifter.sv
module sws_shifter
  import sws_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  localparam int CNT_W    = $clog2(NUM_BYTES + 1),
  localparam int TOT_W    = NUM_BYTES * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [CNT_W-1:0] n_bytes,
  input  logic [TOT_W-1:0] pattern,
  output logic             msb
);

  logic [TOT_W-1:0] stream;
  logic [TOT_W-1:0] shreg;

  // Reorder: byte 0 goes to the top so it leaves first.
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_order
    assign stream[(NUM_BYTES-1-i)*BYTE_W +: BYTE_W] = pattern[i*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      shreg <= '0;
    else if (load)
      shreg <= stream << sws_skip_bits(32'(n_bytes), BYTE_W, NUM_BYTES);
    else if (shift)
      shreg <= {shreg[TOT_W-2:0], 1'b0};
  end

  assign msb = shreg[TOT_W-1];

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(shreg)); // R7

endmodule

// File: rtl/sws_ctrl.sv
module sws_ctrl
  import sws_pkg::*;
#(
  parameter int BITS_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bit_en,
  input  logic [BITS_W-1:0] n_bits,
  output logic              load,
  output logic              empty_start,
  output logic              take,
  output logic              last_take,
  output logic              busy,
  output logic              done
);

  sws_state_e        state;
  logic [BITS_W-1:0] bits_left;
  logic              accept;

  assign accept      = start && (state == SWS_IDLE);
  assign load        = accept && (n_bits != '0);
  assign empty_start = accept && (n_bits == '0);
  assign take        = (state == SWS_SEND) && bit_en;
  assign last_take   = take && (bits_left == BITS_W'(1));
  assign busy        = (state == SWS_SEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SWS_IDLE;
      bits_left <= '0;
      done      <= 1'b0;
    end else begin
      done <= last_take || empty_start;
      case (state)
        SWS_IDLE: if (load) begin
          state     <= SWS_SEND;
          bits_left <= n_bits;
        end
        SWS_SEND: if (take) begin
          bits_left <= bits_left - BITS_W'(1);
          if (last_take) state <= SWS_IDLE;
        end
        default: state <= SWS_IDLE;
      endcase
    end
  end

  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bits_left != '0)); // R8
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> (!busy && done)); // R8
  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    empty_start |=> (done && !busy)); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !bit_en) |=> (busy && $stable(bits_left))); // R9
  AST_LOAD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy); // R11

endmodule

// File: rtl/sws_tx_serializer.sv
module sws_tx_serializer
  import sws_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  parameter int LEN_W     = 5,
  localparam int CNT_W    = $clog2(NUM_BYTES + 1),
  localparam int BITS_W   = $clog2(NUM_BYTES * BYTE_W + 1),
  localparam int TOT_W    = NUM_BYTES * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             bit_en,
  input  logic [TOT_W-1:0] sync_pattern,
  input  logic [LEN_W-1:0] sync_len,
  output logic             sdata,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0]  n_bytes;
  logic [BITS_W-1:0] n_bits;
  logic              load;
  logic              empty_start;
  logic              take;
  logic              last_take;
  logic              msb;

  sws_len_decode #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .LEN_W(LEN_W)) u_dec (
    .len     (sync_len),
    .n_bytes (n_bytes),
    .n_bits  (n_bits)
  );

  sws_ctrl #(.BITS_W(BITS_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .bit_en      (bit_en),
    .n_bits      (n_bits),
    .load        (load),
    .empty_start (empty_start),
    .take        (take),
    .last_take   (last_take),
    .busy        (busy),
    .done        (done)
  );

  sws_shifter #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .shift   (take),
    .n_bytes (n_bytes),
    .pattern (sync_pattern),
    .msb     (msb)
  );

  assign sdata = busy && msb;

  AST_DONE_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sdata); // R1
  AST_HOLD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_en) |=> $stable(sdata)); // R7

endmodule

// File: tb/sws_tx_serializer_tb.sv
module sws_tx_serializer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        bit_en = 1'b0;
  logic [23:0] sync_pattern = '0;
  logic [4:0]  sync_len = '0;
  logic        sdata;
  logic        busy;
  logic        done;

  int vectors = 0;
  int miscompares = 0;
  bit exp_q[$];
  string cur_req = "R1";

  always #2 clk = ~clk;

  sws_tx_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_en(bit_en),
    .sync_pattern(sync_pattern), .sync_len(sync_len),
    .sdata(sdata), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: each taken bit is compared against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && busy && bit_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, {cur_req, " extra bit"}, int'(sdata), -1);
      end else begin
        bit e;
        e = exp_q.pop_front();
        check(sdata === e, {cur_req, " R6 bit"}, int'(sdata), int'(e));
      end
    end
  end

  task automatic push_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]); // R6 msb first
  endtask

  task automatic run_frame(input logic [7:0] lo, input logic [7:0] mid,
                           input logic [7:0] hi, input logic [4:0] len,
                           input int gap, input bit poke, input string req);
    int k;
    cur_req = req;
    if (len == 0) begin
    end else if (len < 8) begin
      push_byte(hi);
    end else if (len <= 16) begin
      push_byte(mid); push_byte(hi);
    end else begin
      push_byte(lo); push_byte(mid); push_byte(hi);
    end
    sync_pattern = {hi, mid, lo};
    sync_len = len;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (len == 0) begin
      check(done === 1'b1 && busy === 1'b0, "R5 empty done", int'(done), 1);
    end else begin
      check(busy === 1'b1, "R11 busy rise", int'(busy), 1);
      check(sdata === exp_q[0], "R11 first bit", int'(sdata), int'(exp_q[0]));
      k = 0;
      while (busy) begin
        bit_en = (gap == 0) ? 1'b1 : ((k % gap) != 1);
        if (poke && k == 5) begin
          start = 1'b1;                  // R9 start while busy
          sync_pattern = ~sync_pattern;  // R10 edits mid transfer
          sync_len = 5'd0;
        end else begin
          start = 1'b0;
        end
        k++;
        @(posedge clk); #1;
      end
      bit_en = 1'b0;
      start = 1'b0;
      check(done === 1'b1, {req, " R8 done"}, int'(done), 1);
      check(exp_q.size() == 0, {req, " bit count"}, exp_q.size(), 0);
    end
    @(posedge clk); #1;
    check(done === 1'b0 && busy === 1'b0, "R8 one-cycle done R9 no restart",
          int'({busy, done}), 0);
    exp_q.delete();
  endtask

  initial begin
    #3;
    check(busy === 1'b0 && done === 1'b0 && sdata === 1'b0, "R1 reset",
          int'({busy, done, sdata}), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R7: bit_en while idle does nothing
    bit_en = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check(busy === 1'b0 && done === 1'b0 && sdata === 1'b0, "R7 idle bit_en",
          int'({busy, done, sdata}), 0);
    bit_en = 1'b0;

    run_frame(8'hA5, 8'h3C, 8'hD2, 5'd24, 0, 1'b0, "R2");
    run_frame(8'h01, 8'h80, 8'h7E, 5'd17, 3, 1'b0, "R2");
    run_frame(8'hF0, 8'h0F, 8'h55, 5'd31, 2, 1'b0, "R2");
    run_frame(8'hFF, 8'hC3, 8'h96, 5'd16, 0, 1'b0, "R3");
    run_frame(8'hFF, 8'h81, 8'h18, 5'd8,  3, 1'b0, "R3");
    run_frame(8'h00, 8'h6A, 8'hE1, 5'd15, 0, 1'b0, "R3");
    run_frame(8'hAA, 8'hBB, 8'hC7, 5'd7,  3, 1'b0, "R4");
    run_frame(8'hAA, 8'hBB, 8'h4D, 5'd1,  0, 1'b0, "R4");
    run_frame(8'h12, 8'h34, 8'h56, 5'd0,  0, 1'b0, "R5");
    run_frame(8'h9C, 8'h2B, 8'hE8, 5'd20, 3, 1'b1, "R9 R10");
    run_frame(8'h9C, 8'h2B, 8'hE8, 5'd5,  0, 1'b1, "R9 R10");
    run_frame(8'h00, 8'h00, 8'h00, 5'd0,  0, 1'b0, "R5");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule